// File: doc/BRIEF.md
# Packet Memory Pointer and Data Window

This block gives a host byte-wide access to a paged packet store. The host loads a 16-bit address pointer as two byte writes. It then reads or writes packet bytes through a window of four consecutive register addresses. Two pointer bits set the access behaviour. The top bit picks the page: either the page at the head of the receive queue, or the page the host selected. A second bit picks how the window is addressed. In stepping mode the pointer advances by one after each access. In lane mode the pointer stays put and the window's lane number is added to it.

The page store sits inside the block as a synchronous RAM. It holds four pages of 2048 bytes each. The receive-head page number and the host-selected page number arrive as inputs from the surrounding queue and allocator logic. Every read, whether of a RAM byte or a pointer byte, answers exactly one cycle after its request, marked by a one-cycle valid pulse.

Top module: `pkt_data_port`

## Requirements
- R1: Register address 0 writes pointer bits 7:0 and address 1 writes pointer bits 15:8; reading address 0 returns pointer bits 7:0; after reset the pointer is 0x0000.
- R2: Reading register address 1 returns pointer bits 15:8 ANDed with 0xF7, so bit 11 of the pointer always reads back as 0.
- R3: When pointer bit 15 is 1, window accesses target the page given by `rx_head_page`.
- R4: When pointer bit 15 is 0, window accesses target the page given by `host_page`.
- R5: When pointer bit 14 is 1, a window access (addresses 4 to 7, read or write) uses offset = pointer bits 10:0 whatever the lane, then adds one to bits 10:0 while bits 15:11 keep their value.
- R6: The offset arithmetic wraps modulo 2048: stepping from 0x7FF gives 0x000, and in lane mode offset 0x7FE plus lane 2 gives 0x000.
- R7: When pointer bit 14 is 0, a window access at address 4+k (k = 0..3) uses offset = (pointer bits 10:0 + k) mod 2048, and the pointer does not change.
- R8: A read request gives `rd_valid` high exactly one cycle later, with the byte on `rd_data` in that cycle; writes never raise `rd_valid`.
- R9: A window write changes only the addressed byte; neighbouring bytes that share the same RAM word keep their values.
- R10: Reads of register addresses 2 and 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | 0 pointer low, 1 pointer high, 2-3 reserved, 4-7 data window lanes 0-3 |
| req_wdata | input | 8 | Write byte |
| rx_head_page | input | 2 | Page number at the head of the receive queue |
| host_page | input | 2 | Page number selected by the host |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 8 | Read byte |

## Verification
Bytes are written in stepping mode through every lane address. They are then read back in lane mode. This shows that stepping ignores the lane, and that lane mode adds the lane without moving the pointer. The same offset is filled with different bytes on different pages. Reading it with each setting of the page-select bit, and with each of the two page inputs, shows which source chose the page. Runs that start at offset 0x7FE, in both modes, expose any offset arithmetic wider than 11 bits. A single-byte overwrite inside a filled word separates a true byte write from a whole-word write.

// File: rtl/pdp_pkg.sv
// Package: shared constants for the packet data port.
// Assumes a 16-bit pointer whose control bits sit above the byte offset.
package pdp_pkg;
    localparam int PTR_W        = 16;
    localparam int PTR_RXSEL    = 15;    // 1: receive-head page
    localparam int PTR_STEP     = 14;    // 1: advance after each access
    localparam logic [7:0] PTR_HI_RDMASK = 8'hF7;

    // Register addresses inside the 3-bit host window
    localparam logic [2:0] RA_PTR_LO = 3'd0;
    localparam logic [2:0] RA_PTR_HI = 3'd1;

    // Source of the byte returned on a read
    typedef enum logic [0:0] {
        RD_FROM_REG = 1'b0,
        RD_FROM_RAM = 1'b1
    } rd_src_e;
endpackage

// File: rtl/pdp_pointer.sv
// Module: pointer register.
// Holds the 16-bit pointer. The host loads it byte by byte. It steps
// the offset field when told to. Assumes at most one request per cycle.
module pdp_pointer
    import pdp_pkg::*;
#(
    parameter int OFF_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wbyte,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    logic [PTR_W-1:0] ptr_q;

    // Update the pointer from host writes or from offset stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_lo) begin
            ptr_q[7:0] <= wbyte;
        end else if (wr_hi) begin
            ptr_q[PTR_W-1:8] <= wbyte;
        end else if (step) begin
            ptr_q[OFF_W-1:0] <= ptr_q[OFF_W-1:0] + 1'b1;
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/pdp_addr_gen.sv
// Module: window address generator.
// Turns the pointer fields and the lane into a page number and a byte
// offset. Purely combinational; offsets wrap inside OFF_W bits.
module pdp_addr_gen #(
    parameter int PAGE_W = 2,
    parameter int OFF_W  = 11,
    parameter int LANE_W = 2
) (
    input  logic              sel_rx,
    input  logic              step_mode,
    input  logic [OFF_W-1:0]  base_off,
    input  logic [LANE_W-1:0] lane,
    input  logic [PAGE_W-1:0] rx_head_page,
    input  logic [PAGE_W-1:0] host_page,
    output logic [PAGE_W-1:0] page,
    output logic [OFF_W-1:0]  offset
);
    // Choose the page and form the byte offset
    always_comb begin
        page   = sel_rx ? rx_head_page : host_page;
        offset = step_mode ? base_off : base_off + OFF_W'(lane);
    end
endmodule

// File: rtl/pdp_ram.sv
// Module: packet page store.
// Synchronous RAM organised as words of 2**LANE_W bytes, with byte-lane
// writes. A read returns the addressed byte one cycle after the request.
module pdp_ram #(
    parameter int PAGE_W = 2,
    parameter int OFF_W  = 11,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [PAGE_W-1:0] page,
    input  logic [OFF_W-1:0]  offset,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int NB     = 1 << LANE_W;
    localparam int WA_W   = PAGE_W + OFF_W - LANE_W;
    localparam int DEPTH  = 1 << WA_W;

    logic [NB-1:0][7:0] mem [DEPTH];
    logic [NB-1:0][7:0] rword_q;
    logic [LANE_W-1:0]  sel_q;
    logic [WA_W-1:0]    waddr;
    logic [LANE_W-1:0]  sel;

    assign waddr = {page, offset[OFF_W-1:LANE_W]};
    assign sel   = offset[LANE_W-1:0];

    // Write one byte lane, or fetch a whole word for a read
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[waddr][sel] <= wdata;
            end else begin
                rword_q <= mem[waddr];
                sel_q   <= sel;
            end
        end
    end

    assign rdata = rword_q[sel_q];
endmodule

// File: rtl/pkt_data_port.sv
// Module: packet data port (top).
// Decodes host accesses to the pointer bytes and the data window, feeds
// the page store, and returns every read one cycle after its request.
// Assumes the page inputs stay stable during the cycle of an access.
module pkt_data_port
    import pdp_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int OFF_W  = 11,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LANE_W:0]   req_addr,
    input  logic [7:0]        req_wdata,
    input  logic [PAGE_W-1:0] rx_head_page,
    input  logic [PAGE_W-1:0] host_page,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    logic [PTR_W-1:0]  ptr_q;
    logic              is_win, win_acc, wr_lo, wr_hi, rd_req, step;
    logic [PAGE_W-1:0] acc_page;
    logic [OFF_W-1:0]  acc_off;
    logic [7:0]        ram_rdata;
    logic [7:0]        reg_byte;
    logic [7:0]        snap_q;
    rd_src_e           src_q;
    logic              rd_valid_q;

    // Decode the host request
    always_comb begin
        is_win  = req_addr[LANE_W];
        win_acc = req_valid && is_win;
        rd_req  = req_valid && !req_write;
        wr_lo   = req_valid && req_write && (req_addr == RA_PTR_LO);
        wr_hi   = req_valid && req_write && (req_addr == RA_PTR_HI);
        step    = win_acc && ptr_q[PTR_STEP];
    end

    pdp_pointer #(.OFF_W(OFF_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wbyte (req_wdata),
        .step  (step),
        .ptr   (ptr_q)
    );

    pdp_addr_gen #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_agen (
        .sel_rx       (ptr_q[PTR_RXSEL]),
        .step_mode    (ptr_q[PTR_STEP]),
        .base_off     (ptr_q[OFF_W-1:0]),
        .lane         (req_addr[LANE_W-1:0]),
        .rx_head_page (rx_head_page),
        .host_page    (host_page),
        .page         (acc_page),
        .offset       (acc_off)
    );

    pdp_ram #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_ram (
        .clk    (clk),
        .en     (win_acc),
        .we     (req_write),
        .page   (acc_page),
        .offset (acc_off),
        .wdata  (req_wdata),
        .rdata  (ram_rdata)
    );

    // Pick the register byte a non-window read returns
    always_comb begin
        if (req_addr == RA_PTR_LO)
            reg_byte = ptr_q[7:0];
        else if (req_addr == RA_PTR_HI)
            reg_byte = ptr_q[PTR_W-1:8] & PTR_HI_RDMASK;
        else
            reg_byte = 8'h00;
    end

    // Register the read strobe, its source and any register byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            src_q      <= RD_FROM_REG;
            snap_q     <= 8'h00;
        end else begin
            rd_valid_q <= rd_req;
            if (rd_req) begin
                src_q  <= is_win ? RD_FROM_RAM : RD_FROM_REG;
                snap_q <= reg_byte;
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = (src_q == RD_FROM_RAM) ? ram_rdata : snap_q;
endmodule

// File: rtl/pdp_checker.sv
// Module: property checker for the packet data port, bound to the top.
module pdp_checker
    import pdp_pkg::*;
#(
    parameter int OFF_W  = 11,
    parameter int LANE_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [LANE_W:0]  req_addr,
    input logic             rd_valid,
    input logic [7:0]       rd_data,
    input logic [PTR_W-1:0] ptr
);
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);  // R8

    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);  // R8

    AST_LANE_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[LANE_W] && !ptr[PTR_STEP]) |=> $stable(ptr));  // R7

    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[LANE_W] && ptr[PTR_STEP])
        |=> ptr[OFF_W-1:0] == OFF_W'($past(ptr[OFF_W-1:0]) + 1'b1));  // R5

    AST_STEP_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[LANE_W] && ptr[PTR_STEP])
        |=> ptr[PTR_W-1:OFF_W] == $past(ptr[PTR_W-1:OFF_W]));  // R5

    AST_HI_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == RA_PTR_HI)
        |=> (rd_data & ~PTR_HI_RDMASK) == 8'h00);  // R2
endmodule

bind pkt_data_port pdp_checker #(.OFF_W(OFF_W), .LANE_W(LANE_W)) u_pdp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .ptr       (ptr_q)
);

// File: tb/tb_pkt_data_port.sv
`timescale 1ns/1ps
module tb_pkt_data_port;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, req_write;
    logic [2:0] req_addr;
    logic [7:0] req_wdata;
    logic [1:0] rx_head_page, host_page;
    logic       rd_valid;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    pkt_data_port dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rx_head_page(rx_head_page),
        .host_page(host_page), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t      sbq[$];
    int         total = 0;
    int         bad   = 0;
    logic [15:0] mptr;
    logic [7:0] mmem [int];

    // Target byte index from the model pointer and a lane
    function automatic int target(input logic [1:0] lane);
        logic [1:0]  pg;
        logic [10:0] off;
        pg  = mptr[15] ? rx_head_page : host_page;
        off = mptr[14] ? mptr[10:0] : mptr[10:0] + {9'd0, lane};
        return int'(pg) * 2048 + int'(off);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        if (a == 3'd0) mptr[7:0] = d;
        else if (a == 3'd1) mptr[15:8] = d;
        else if (a[2]) begin
            mmem[target(a[1:0])] = d;
            if (mptr[14]) mptr[10:0] = mptr[10:0] + 11'd1;
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic setptr(input logic [15:0] p);
        wr(3'd1, p[15:8]);
        wr(3'd0, p[7:0]);
    endtask

    // Read with a literal expected byte; the monitor compares it
    task automatic rdx(input logic [2:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        if (a[2] && mptr[14]) mptr[10:0] = mptr[10:0] + 11'd1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Read with the expected byte taken from the bench model
    task automatic rdm(input logic [2:0] a, input string tag);
        logic [7:0] e;
        if (a == 3'd0) e = mptr[7:0];
        else if (a == 3'd1) e = mptr[15:8] & 8'hF7;
        else if (!a[2]) e = 8'h00;
        else e = mmem[target(a[1:0])];
        rdx(a, e, tag);
    endtask

    // Monitor: pop an expected item whenever read data appears
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rd_valid === 1'b1) begin
            total++;
            if (sbq.size() == 0) begin
                bad++;
                $display("FAIL R8 rd_valid with no read pending: actual=1 expected=0");
            end else begin
                item_t it;
                it = sbq.pop_front();
                if (rd_data !== it.exp) begin
                    bad++;
                    $display("FAIL %s rd_data actual=%02h expected=%02h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; rx_head_page = '0; host_page = '0; mptr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset value and byte loads; R2 high-byte mask
        rdx(3'd0, 8'h00, "R1");
        rdx(3'd1, 8'h00, "R1");
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
        rdx(3'd0, 8'hFF, "R1");
        rdx(3'd1, 8'hF7, "R2");

        // Same offset on two pages, then page selection (R3, R4)
        host_page = 2'd0; setptr(16'h4000); wr(3'd4, 8'hA0);
        host_page = 2'd1; setptr(16'h4000); wr(3'd4, 8'hB1);
        setptr(16'h8000);
        rx_head_page = 2'd1; rdx(3'd4, 8'hB1, "R3");
        rx_head_page = 2'd0; rdx(3'd4, 8'hA0, "R3");
        wr(3'd1, 8'h00);
        host_page = 2'd1; rdx(3'd4, 8'hB1, "R4");
        host_page = 2'd0; rdx(3'd4, 8'hA0, "R4");

        // R5: stepping writes ignore the lane
        host_page = 2'd2; setptr(16'h4010);
        wr(3'd5, 8'h11); wr(3'd6, 8'h22); wr(3'd7, 8'h33); wr(3'd4, 8'h44);
        rdx(3'd0, 8'h14, "R5");
        rdx(3'd1, 8'h40, "R5");
        // R7: lane mode adds the lane and holds the pointer
        setptr(16'h0010);
        rdx(3'd4, 8'h11, "R7"); rdx(3'd5, 8'h22, "R7");
        rdx(3'd6, 8'h33, "R7"); rdx(3'd7, 8'h44, "R7");
        rdx(3'd0, 8'h10, "R7");
        // R5: stepping reads
        setptr(16'h4010);
        rdx(3'd7, 8'h11, "R5"); rdx(3'd4, 8'h22, "R5");
        rdx(3'd0, 8'h12, "R5");

        // R6: wrap in stepping mode with upper bits preserved
        host_page = 2'd3; setptr(16'h5FFE);
        wr(3'd4, 8'hC1); wr(3'd4, 8'hC2); wr(3'd4, 8'hC3);
        rdx(3'd0, 8'h01, "R6");
        rdx(3'd1, 8'h50, "R6");
        // R6: wrap in lane mode
        setptr(16'h07FE);
        rdx(3'd6, 8'hC3, "R6");
        rdx(3'd5, 8'hC2, "R6");
        rdx(3'd4, 8'hC1, "R6");

        // R9: single byte overwrite inside a word
        host_page = 2'd0; setptr(16'h0020);
        wr(3'd4, 8'h01); wr(3'd5, 8'h02); wr(3'd6, 8'h03); wr(3'd7, 8'h04);
        wr(3'd5, 8'hAA);
        rdx(3'd4, 8'h01, "R9"); rdx(3'd5, 8'hAA, "R9");
        rdx(3'd6, 8'h03, "R9"); rdx(3'd7, 8'h04, "R9");

        // R10: reserved addresses read zero
        rdx(3'd2, 8'h00, "R10");
        rdx(3'd3, 8'h00, "R10");

        // R8: a write gives no read strobe in the following cycle
        wr(3'd0, 8'h20);
        total++;
        if (rd_valid !== 1'b0) begin
            bad++;
            $display("FAIL R8 rd_valid after write actual=%0b expected=0", rd_valid);
        end

        // R3 with stepping over a receive-head page, model-based
        host_page = 2'd1; rx_head_page = 2'd2; setptr(16'hC100);
        for (int i = 0; i < 8; i++) wr(3'(4 + (i % 4)), 8'(i * 7 + 3));
        setptr(16'h8100);
        for (int i = 0; i < 4; i++) rdm(3'(4 + i), "R3");
        setptr(16'hC104);
        for (int i = 0; i < 4; i++) rdm(3'd4, "R5");
        rdm(3'd0, "R5");
        rdm(3'd1, "R2");

        repeat (3) @(negedge clk);
        total++;
        if (sbq.size() != 0) begin
            bad++;
            $display("FAIL R8 reads left unanswered actual=%0d expected=0", sbq.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule